// File: doc/BRIEF.md
# Shared Pin Multiplexer

This block lets several on-chip peripherals take turns on one set of package pins. The pins are split into groups. A firmware-written owner code per group selects which peripheral drives that group's output and output-enable lines. A code that names no peripheral leaves the group undriven. The output side is a pure selection mux, so at any moment a pin has exactly one source or none.

On the input side, the pin input first passes through a two-flop synchronizer. It is then fanned out under a per-peripheral route mask. Every peripheral whose mask bit is set sees the live, synchronized pin value, and several may be enabled at once. A peripheral whose mask bit is clear sees a constant taken from a per-peripheral idle-level register. Firmware programs that register with each peripheral's deasserted levels, for example "not ready", so a detached peripheral never reacts to traffic meant for another one.

Configuration is write-only, through a single write strobe, a 2-bit register code and a data word. After reset no peripheral owns any pin group, all output enables are low, and every peripheral sees its reset idle level.

Top module: `shared_pin_mux`

## Requirements
- R1: While reset is held and in the first cycle after it, `pin_oe` and `pin_out` are all zero and `blk_in` equals the parameter `IDLE_RST`. That parameter defaults to 12'hF0F: block 0 and block 2 idle high, block 1 idle low.
- R2: When the owner code of group g is a block number b below `NUM_BLK`, the pins of group g carry `blk_out` and `blk_oe` of block b at the same pin positions. Block b, pin p sits at bit b*PIN_W+p. Group g covers pins g*GRP_W to g*GRP_W+GRP_W-1.
- R3: An owner code of `NUM_BLK` or above (code 3 in the default configuration) drives the group's `pin_out` and `pin_oe` to zero.
- R4: A write to register code 0 (owner) captures `cfg_wdata` bits [2g+1:2g] as the owner code of group g at the write's clock edge. Up to that edge the previous owner still drives the pins; from that edge on only the new owner does.
- R5: A block whose route bit is set receives `pin_in` delayed by exactly two clock edges.
- R6: A block whose route bit is clear sees its idle level, whatever `pin_in` does.
- R7: The route mask, written with register code 1 (bit b = block b), may enable any subset of blocks, and every enabled block receives the same pin value.
- R8: A write to register code 2 replaces the idle levels (bit b*PIN_W+p for block b, pin p). The new levels appear on every unrouted block after the write edge.
- R9: A write to register code 3 changes nothing visible on `pin_out`, `pin_oe` or `blk_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register code: 0 owner, 1 route mask, 2 idle levels, 3 unused |
| cfg_wdata | input | CFG_W (16) | Configuration write data |
| blk_out | input | NUM_BLK*PIN_W (12) | Output value of each peripheral, per pin |
| blk_oe | input | NUM_BLK*PIN_W (12) | Output enable of each peripheral, per pin |
| blk_in | output | NUM_BLK*PIN_W (12) | Input value delivered to each peripheral, per pin |
| pin_out | output | PIN_W (4) | Value driven toward the pins |
| pin_oe | output | PIN_W (4) | Output enable toward the pins |
| pin_in | input | PIN_W (4) | Value arriving from the pins |

## Verification
The assertions assume that `pin_in`, `blk_out`, `blk_oe` and the configuration inputs change only away from the rising clock edge. They also assume that the route mask is zero during reset, so that no block expects the synchronizer to have sampled the pin before reset released. The bench changes every input at the falling edge and programs the route mask only after reset. The synchronizer-latency property looks back only across cycles in which the route bit was already set, so it stays within the time since reset.

// File: rtl/pinmux_pkg.sv
// Package: shared definitions for the shared pin multiplexer.
// Assumes: register codes are two bits wide and decoded by pinmux_cfg_regs.
package pinmux_pkg;

    // Register codes selected by cfg_addr.
    typedef enum logic [1:0] {
        REG_OWNER = 2'd0,
        REG_ROUTE = 2'd1,
        REG_IDLE  = 2'd2,
        REG_SPARE = 2'd3
    } pm_reg_e;

endpackage

// File: rtl/pinmux_cfg_regs.sv
// Module: configuration registers (owner codes, route mask, idle levels).
// Assumes: the write path is single-cycle and write-only; the spare code is ignored.
module pinmux_cfg_regs #(
    parameter int NUM_BLK = 3,
    parameter int N_GRP   = 2,
    parameter int PIN_W   = 4,
    parameter int CFG_W   = 16,
    parameter int SEL_W   = 2,
    parameter logic [NUM_BLK*PIN_W-1:0] IDLE_RST = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [1:0]               cfg_addr,
    input  logic [CFG_W-1:0]         cfg_wdata,
    output logic [N_GRP*SEL_W-1:0]   owner_sel,
    output logic [NUM_BLK-1:0]       route_en,
    output logic [NUM_BLK*PIN_W-1:0] idle_lvl
);
    import pinmux_pkg::*;

    localparam int OWN_W  = N_GRP * SEL_W;
    localparam int IDLE_W = NUM_BLK * PIN_W;
    localparam logic [OWN_W-1:0] OWN_RST = {N_GRP{SEL_W'(NUM_BLK)}};

    logic unused_wdata;
    assign unused_wdata = ^cfg_wdata;

    // Register update: reset to "no owner", empty route mask and reset idle levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_sel <= OWN_RST;
            route_en  <= '0;
            idle_lvl  <= IDLE_RST;
        end else if (cfg_we) begin
            case (pm_reg_e'(cfg_addr))
                REG_OWNER: owner_sel <= cfg_wdata[OWN_W-1:0];
                REG_ROUTE: route_en  <= cfg_wdata[NUM_BLK-1:0];
                REG_IDLE:  idle_lvl  <= cfg_wdata[IDLE_W-1:0];
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/pinmux_out_sel.sv
// Module: output selector for one pin group.
// Assumes: a select code at or above NUM_BLK means no owner; the group is then undriven.
module pinmux_out_sel #(
    parameter int NUM_BLK = 3,
    parameter int GRP_W   = 2,
    parameter int SEL_W   = 2
) (
    input  logic [SEL_W-1:0]         sel,
    input  logic [NUM_BLK*GRP_W-1:0] gb_out,
    input  logic [NUM_BLK*GRP_W-1:0] gb_oe,
    output logic [GRP_W-1:0]         grp_out,
    output logic [GRP_W-1:0]         grp_oe
);

    // Pick the owning block's slice; default to an undriven group.
    always_comb begin
        grp_out = '0;
        grp_oe  = '0;
        for (int b = 0; b < NUM_BLK; b++) begin
            if (sel == SEL_W'(b)) begin
                grp_out = gb_out[b*GRP_W +: GRP_W];
                grp_oe  = gb_oe[b*GRP_W +: GRP_W];
            end
        end
    end

endmodule

// File: rtl/pinmux_in_route.sv
// Module: pin input synchronizer and per-block input distribution.
// Assumes: pin_in is asynchronous; a block with its route bit clear sees its idle level.
module pinmux_in_route #(
    parameter int NUM_BLK = 3,
    parameter int PIN_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PIN_W-1:0]         pin_in,
    input  logic [NUM_BLK-1:0]       route_en,
    input  logic [NUM_BLK*PIN_W-1:0] idle_lvl,
    output logic [NUM_BLK*PIN_W-1:0] blk_in
);

    logic [PIN_W-1:0] sync_a;
    logic [PIN_W-1:0] sync_b;

    // Two-flop synchronizer on the pin input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= '0;
            sync_b <= '0;
        end else begin
            sync_a <= pin_in;
            sync_b <= sync_a;
        end
    end

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
        // Live pin value when routed, constant idle level otherwise.
        assign blk_in[b*PIN_W +: PIN_W] = route_en[b] ? sync_b : idle_lvl[b*PIN_W +: PIN_W];
    end

endmodule

// File: rtl/shared_pin_mux.sv
// Module: top of the shared pin multiplexer.
// Assumes: block b, pin p sits at bit b*PIN_W+p of the block-side vectors;
// pin group g covers pins g*GRP_W .. g*GRP_W+GRP_W-1.
module shared_pin_mux #(
    parameter int NUM_BLK = 3,
    parameter int N_GRP   = 2,
    parameter int GRP_W   = 2,
    parameter int CFG_W   = 16,
    parameter logic [NUM_BLK*N_GRP*GRP_W-1:0] IDLE_RST = 12'hF0F
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cfg_we,
    input  logic [1:0]                           cfg_addr,
    input  logic [CFG_W-1:0]                     cfg_wdata,
    input  logic [NUM_BLK*N_GRP*GRP_W-1:0]       blk_out,
    input  logic [NUM_BLK*N_GRP*GRP_W-1:0]       blk_oe,
    output logic [NUM_BLK*N_GRP*GRP_W-1:0]       blk_in,
    output logic [N_GRP*GRP_W-1:0]               pin_out,
    output logic [N_GRP*GRP_W-1:0]               pin_oe,
    input  logic [N_GRP*GRP_W-1:0]               pin_in
);

    localparam int PIN_W = N_GRP * GRP_W;
    localparam int SEL_W = $clog2(NUM_BLK + 1);

    logic [N_GRP*SEL_W-1:0]   owner_sel;
    logic [NUM_BLK-1:0]       route_en;
    logic [NUM_BLK*PIN_W-1:0] idle_lvl;

    pinmux_cfg_regs #(
        .NUM_BLK (NUM_BLK),
        .N_GRP   (N_GRP),
        .PIN_W   (PIN_W),
        .CFG_W   (CFG_W),
        .SEL_W   (SEL_W),
        .IDLE_RST(IDLE_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .owner_sel(owner_sel),
        .route_en (route_en),
        .idle_lvl (idle_lvl)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        logic [NUM_BLK*GRP_W-1:0] gb_out;
        logic [NUM_BLK*GRP_W-1:0] gb_oe;

        for (genvar b = 0; b < NUM_BLK; b++) begin : g_gather
            // Collect this group's pins from every block.
            assign gb_out[b*GRP_W +: GRP_W] = blk_out[b*PIN_W + g*GRP_W +: GRP_W];
            assign gb_oe[b*GRP_W +: GRP_W]  = blk_oe[b*PIN_W + g*GRP_W +: GRP_W];
        end

        pinmux_out_sel #(
            .NUM_BLK(NUM_BLK),
            .GRP_W  (GRP_W),
            .SEL_W  (SEL_W)
        ) u_sel (
            .sel    (owner_sel[g*SEL_W +: SEL_W]),
            .gb_out (gb_out),
            .gb_oe  (gb_oe),
            .grp_out(pin_out[g*GRP_W +: GRP_W]),
            .grp_oe (pin_oe[g*GRP_W +: GRP_W])
        );
    end

    pinmux_in_route #(
        .NUM_BLK(NUM_BLK),
        .PIN_W  (PIN_W)
    ) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .route_en(route_en),
        .idle_lvl(idle_lvl),
        .blk_in  (blk_in)
    );

endmodule

// File: rtl/shared_pin_mux_chk.sv
// Module: assertion checker for shared_pin_mux, attached by bind.
// Assumes: inputs change away from the rising edge; route mask is zero during reset.
module shared_pin_mux_chk #(
    parameter int NUM_BLK = 3,
    parameter int N_GRP   = 2,
    parameter int GRP_W   = 2,
    parameter int CFG_W   = 16,
    parameter logic [NUM_BLK*N_GRP*GRP_W-1:0] IDLE_RST = '0
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cfg_we,
    input logic [1:0]                     cfg_addr,
    input logic [CFG_W-1:0]               cfg_wdata,
    input logic [NUM_BLK*N_GRP*GRP_W-1:0] blk_oe,
    input logic [NUM_BLK*N_GRP*GRP_W-1:0] blk_in,
    input logic [N_GRP*GRP_W-1:0]         pin_oe,
    input logic [N_GRP*GRP_W-1:0]         pin_out,
    input logic [N_GRP*GRP_W-1:0]         pin_in,
    input logic [N_GRP*$clog2(NUM_BLK+1)-1:0] owner_sel,
    input logic [NUM_BLK-1:0]             route_en,
    input logic [NUM_BLK*N_GRP*GRP_W-1:0] idle_lvl
);
    localparam int PIN_W = N_GRP * GRP_W;
    localparam int SEL_W = $clog2(NUM_BLK + 1);
    localparam int OWN_W = N_GRP * SEL_W;

    // R1: first cycle after reset shows no driver and the reset idle levels.
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pin_oe == '0 && pin_out == '0 && blk_in == IDLE_RST));

    // R4: an owner write is visible right after its edge.
    p_owner_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 2'd0) |=> owner_sel == $past(cfg_wdata[OWN_W-1:0]));

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        // R3: no owner means an undriven group.
        p_no_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (owner_sel[g*SEL_W +: SEL_W] >= SEL_W'(NUM_BLK)) |-> pin_oe[g*GRP_W +: GRP_W] == '0);
    end

    for (genvar p = 0; p < PIN_W; p++) begin : g_pin
        logic any_oe;
        // Collect whether any block asks to drive this pin.
        always_comb begin
            any_oe = 1'b0;
            for (int b = 0; b < NUM_BLK; b++) any_oe = any_oe | blk_oe[b*PIN_W + p];
        end
        // R2: a pin is only enabled when some block enables it.
        p_oe_has_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
            pin_oe[p] |-> any_oe);
    end

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
        // R5: a routed block sees the pin two edges late.
        p_sync_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (route_en[b] && $past(route_en[b]) && $past(route_en[b], 2))
            |-> blk_in[b*PIN_W +: PIN_W] == $past(pin_in, 2));
        // R6: an unrouted block's input stays put while its idle level does.
        p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!route_en[b] && !$past(route_en[b]) && $stable(idle_lvl))
            |-> $stable(blk_in[b*PIN_W +: PIN_W]));
    end

endmodule

bind shared_pin_mux shared_pin_mux_chk #(
    .NUM_BLK (NUM_BLK),
    .N_GRP   (N_GRP),
    .GRP_W   (GRP_W),
    .CFG_W   (CFG_W),
    .IDLE_RST(IDLE_RST)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .blk_oe   (blk_oe),
    .blk_in   (blk_in),
    .pin_oe   (pin_oe),
    .pin_out  (pin_out),
    .pin_in   (pin_in),
    .owner_sel(owner_sel),
    .route_en (route_en),
    .idle_lvl (idle_lvl)
);

// File: tb/shared_pin_mux_bench.sv
`timescale 1ns/1ps
// Bench: sweeps owner codes, route masks and pin values on the default configuration.
module shared_pin_mux_bench;
    localparam int NB = 3;
    localparam int PW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [11:0] blk_out = '0;
    logic [11:0] blk_oe = '0;
    logic [11:0] blk_in;
    logic [3:0]  pin_out;
    logic [3:0]  pin_oe;
    logic [3:0]  pin_in = 4'hA;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    shared_pin_mux u_shared_pin_mux (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .blk_out(blk_out), .blk_oe(blk_oe),
        .blk_in(blk_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Register write: drive at the falling edge, held across one rising edge.
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Expected pin side for packed owner codes.
    function automatic logic [7:0] exp_pins(input logic [3:0] own, input logic [11:0] bo,
                                             input logic [11:0] be);
        logic [3:0] o = '0;
        logic [3:0] e = '0;
        for (int g = 0; g < 2; g++) begin
            int s = int'(own[g*2 +: 2]);
            if (s < NB) begin
                o[g*2 +: 2] = bo[s*PW + g*2 +: 2];
                e[g*2 +: 2] = be[s*PW + g*2 +: 2];
            end
        end
        return {e, o};
    endfunction

    // Expected block side for a mask, idle levels and synchronized pin value.
    function automatic logic [11:0] exp_in(input logic [2:0] m, input logic [11:0] idl,
                                            input logic [3:0] p);
        logic [11:0] r;
        for (int b = 0; b < NB; b++)
            r[b*PW +: PW] = m[b] ? p : idl[b*PW +: PW];
        return r;
    endfunction

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] snap;
        logic [11:0] snap_in;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state during reset
        chk("R1 oe in reset", 32'(pin_oe), 32'h0);
        chk("R1 idle in reset", 32'(blk_in), 32'hF0F);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 oe after reset", 32'(pin_oe), 32'h0);
        chk("R1 out after reset", 32'(pin_out), 32'h0);
        chk("R1 idle after reset", 32'(blk_in), 32'hF0F);

        // R2, R3: every owner-code pair against several block patterns
        for (int pat = 0; pat < 6; pat++) begin
            blk_out = 12'((pat * 12'h9A7 + 12'h35C) & 12'hFFF);
            blk_oe  = 12'(~(pat * 12'h4D3) ^ 12'h2B6);
            for (int own = 0; own < 16; own++) begin
                wr(2'd0, 16'(own));
                chk((own[1:0] == 2'd3 || own[3:2] == 2'd3) ? "R3 pins none-owner" : "R2 pins owner",
                    32'({pin_oe, pin_out}), 32'(exp_pins(4'(own), blk_out, blk_oe)));
            end
        end

        // R4: switch owner of both groups from block 0 to block 1
        blk_out = 12'h0A5; blk_oe = 12'hFFF;
        wr(2'd0, 16'h0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 16'h5;
        #1;
        chk("R4 old owner before edge", 32'(pin_out), 32'h5);
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
        chk("R4 new owner after edge", 32'(pin_out), 32'hA);
        chk("R4 oe after edge", 32'(pin_oe), 32'hF);

        // R9: spare code leaves everything alone
        wr(2'd0, 16'h6);
        snap = {pin_oe, pin_out};
        snap_in = blk_in;
        wr(2'd3, 16'hFFFF);
        @(posedge clk); @(negedge clk);
        chk("R9 pins unchanged", 32'({pin_oe, pin_out}), 32'(snap));
        chk("R9 inputs unchanged", 32'(blk_in), 32'(snap_in));

        // R5: latency of exactly two edges
        wr(2'd1, 16'h7);
        pin_in = 4'h0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        pin_in = 4'hF;
        @(posedge clk); @(negedge clk);
        chk("R5 one edge old", 32'(blk_in), 32'h000);
        @(posedge clk); @(negedge clk);
        chk("R5 two edges new", 32'(blk_in), 32'hFFF);

        // R5, R6, R7: every mask against every pin value
        for (int m = 0; m < 8; m++) begin
            wr(2'd1, 16'(m));
            for (int v = 0; v < 16; v++) begin
                pin_in = 4'(v);
                @(posedge clk); @(posedge clk); @(negedge clk);
                chk("R5,R6,R7 routed inputs", 32'(blk_in), 32'(exp_in(3'(m), 12'hF0F, 4'(v))));
            end
        end

        // R8: new idle levels, block 1 routed
        wr(2'd2, 16'h05A3);
        wr(2'd1, 16'h2);
        pin_in = 4'hC;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R8 new idle levels", 32'(blk_in), 32'h5C3);
        pin_in = 4'h1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        // R6: unrouted blocks ignore the pin change
        chk("R6 idle blocks ignore pin", 32'(blk_in), 32'h513);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule